// File: doc/BRIEF.md
# Symbol-Framed Control Word Serializer

This block sits beside a line-coding DSP and feeds a 2B1Q line front end with one 16-bit control word per symbol period. It runs on a clock at 48 times the symbol rate. A symbol-rate clock, sampled in the fast domain, marks where each symbol period begins. Each period is split into 48 bit slots. The word goes out MSB first in the first 16 slots, and the line stays low for the remaining 32.

The word carries the following fields:
- a transmit-enable flag, which forces the zero symbol code when it is cleared;
- a 2-bit symbol code;
- a receive gain code;
- a loopback request;
- a driver boost request.

The host presents these fields as plain levels. The block copies them into a shadow register at the start of each period, so a change made partway through a period appears in the next word. Each bit is launched on the falling edge of the fast clock, which leaves the far end half a cycle to capture it on the rising edge.

Top module: `sym_ctl_serializer`

## Requirements
- R1: The slot counter runs from 0 to 47 and returns to 0 after slot 47, so a new word begins every 48 fast-clock cycles even when no symbol-clock edge arrives.
- R2: During slots 16 to 47 the serial output is 0.
- R3: The word is sent MSB first, and slot k carries word bit 15-k. Bit 15 is the transmit enable, bits 14:13 the symbol code, bits 12:10 the gain code, bit 9 loopback and bit 8 boost. Each bit changes on a falling edge of the fast clock.
- R4: Word bits 7:0 are always sent as 0.
- R5: When transmit enable is 0, bits 14:13 are sent as 00, whatever the symbol input holds. Bit 15 is still sent as 0.
- R6: A rising edge of the symbol clock passes through a two-stage synchronizer and then an edge detector. It forces slot 0 on the third rising fast-clock edge after the symbol clock rises, whatever slot the counter was in.
- R7: After reset, the output stays 0 until the first detected rising edge of the symbol clock.
- R8: The host fields are sampled only on the edge that starts slot 0. A change made later in a period appears in the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_os | input | 1 | Clock at 48 times the symbol rate, running continuously |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_clk | input | 1 | Symbol-rate clock; its rising edge marks a period start |
| tx_en | input | 1 | Transmit enable; 0 forces the zero symbol code |
| sym_code | input | 2 | 2B1Q symbol code |
| rx_gain | input | 3 | Receive gain code |
| loop_on | input | 1 | Loopback request |
| boost | input | 1 | Extra driver power request |
| sdata | output | 1 | Serial control word, launched on falling edges |

## Verification
Random field combinations are sent in periods of 48 cycles, which tie the word position to the symbol-clock edge. They are also sent in periods of 40 to 47 cycles, which show that the counter resynchronizes early rather than running on. Double-length periods with no middle edge show the free wrap after slot 47. In those periods a field change made partway through the first word must appear only in the wrapped word, which separates capture at slot 0 from live sampling. Directed words cover the remaining cases:
- transmit enable cleared with symbol code 11, to separate gating from plain field copying;
- all fields set, to expose a reserved bit or tail slot that is not zero;
- a long stretch with no symbol clock after reset, which must stay quiet.

// File: rtl/sym_ctl_serializer.sv
module sym_ctl_serializer #(
  parameter int SLOTS  = 48,
  parameter int WORD_W = 16,
  parameter int GAIN_W = 3
) (
  input  logic              clk_os,
  input  logic              rst_n,
  input  logic              baud_clk,
  input  logic              tx_en,
  input  logic [1:0]        sym_code,
  input  logic [GAIN_W-1:0] rx_gain,
  input  logic              loop_on,
  input  logic              boost,
  output logic              sdata
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int RSV_W  = WORD_W - 5 - GAIN_W;

  logic [2:0]        bsync;
  logic              locked_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] word_q;

  wire rise  = bsync[1] & ~bsync[2];
  wire last  = slot_q == SLOT_W'(SLOTS - 1);
  wire next0 = rise | (locked_q & last);
  wire in_word = slot_q < SLOT_W'(WORD_W);
  wire [IDX_W-1:0] bit_idx = IDX_W'(WORD_W - 1) - slot_q[IDX_W-1:0];

  wire [WORD_W-1:0] host_word =
    {tx_en, tx_en ? sym_code : 2'b00, rx_gain, loop_on, boost, {RSV_W{1'b0}}};

  always_ff @(posedge clk_os or negedge rst_n) begin
    if (!rst_n) begin
      bsync    <= '0;
      locked_q <= 1'b0;
      slot_q   <= '0;
      word_q   <= '0;
    end else begin
      bsync <= {bsync[1:0], baud_clk};
      if (rise) locked_q <= 1'b1;
      if (next0) begin
        slot_q <= '0;
        word_q <= host_word;
      end else if (locked_q) begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  always_ff @(negedge clk_os or negedge rst_n) begin
    if (!rst_n) sdata <= 1'b0;
    else        sdata <= locked_q & in_word & word_q[bit_idx];
  end

  AST_SLOT_RANGE: assert property (@(posedge clk_os) disable iff (!rst_n)
    slot_q < SLOT_W'(SLOTS)); // R1
  AST_FREE_WRAP: assert property (@(posedge clk_os) disable iff (!rst_n)
    (locked_q && last) |=> slot_q == '0); // R1
  AST_IDLE_TAIL: assert property (@(posedge clk_os) disable iff (!rst_n)
    !in_word |-> !sdata); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_os) disable iff (!rst_n)
    (slot_q >= SLOT_W'(WORD_W - RSV_W) && in_word) |-> !sdata); // R4
  AST_ZERO_SYMBOL: assert property (@(posedge clk_os) disable iff (!rst_n)
    (locked_q && !word_q[WORD_W-1] && (slot_q == 1 || slot_q == 2)) |-> !sdata); // R5
  AST_RESYNC: assert property (@(posedge clk_os) disable iff (!rst_n)
    rise |=> (slot_q == '0 && locked_q)); // R6
  AST_QUIET_UNLOCKED: assert property (@(posedge clk_os) disable iff (!rst_n)
    !locked_q |-> !sdata); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk_os) disable iff (!rst_n)
    !next0 |=> $stable(word_q)); // R8
endmodule

// File: tb/sym_ctl_serializer_test.sv
`timescale 1ns/1ps
module sym_ctl_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_clk = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] sym_code = '0;
  logic [2:0] rx_gain = '0;
  logic       loop_on = 1'b0;
  logic       boost = 1'b0;
  logic       sdata;
  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  sym_ctl_serializer uut (
    .clk_os(clk), .rst_n(rst_n), .baud_clk(baud_clk), .tx_en(tx_en),
    .sym_code(sym_code), .rx_gain(rx_gain), .loop_on(loop_on),
    .boost(boost), .sdata(sdata)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got %0d cycles, expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [15:0] exp_word(input logic [7:0] f);
    return {f[7], f[7] ? f[6:5] : 2'b00, f[4:0], 8'h00};
  endfunction

  function automatic string tag_of(input int b, input logic en);
    if (b < 8) return "R4";
    if ((b == 14 || b == 13) && !en) return "R5";
    return "R3";
  endfunction

  task automatic apply(input logic [7:0] f);
    {tx_en, sym_code, rx_gain, loop_on, boost} = f;
  endtask

  task automatic check(input logic exp, input string tag, input int c);
    vectors++;
    if (sdata !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d of period: got %b expected %b", tag, c, sdata, exp);
    end
  endtask

  // One symbol period of len fast cycles; nxt is applied mid-word (R8).
  task automatic period(input int len, input logic [7:0] cur, input logic [7:0] nxt);
    logic [15:0] w1 = exp_word(cur);
    logic [15:0] w2 = exp_word(nxt);
    @(negedge clk);
    baud_clk = 1'b1;
    apply(cur);
    for (int c = 1; c <= len; c++) begin
      @(posedge clk); #1;
      if (c <= 3)                           check(1'b0, "R6", c);
      else if (c <= 19)                     check(w1[19-c], tag_of(19-c, cur[7]), c);
      else if (len == 96 && c >= 52 && c <= 67)
                                            check(w2[67-c], "R8", c);
      else                                  check(1'b0, len == 96 ? "R1" : "R2", c);
      if (c == 10) apply(nxt);
      if (c == len/2) baud_clk = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    apply(8'hFF);
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R7", 0);
    rst_n = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(posedge clk); #1;
      check(1'b0, "R7", i);
    end
    period(48, 8'h7F, 8'h7F);
    period(48, 8'hFF, 8'hFF);
    period(48, 8'h80, 8'hFF);
    period(96, 8'hA5, 8'hDA);
    period(40, 8'hC3, 8'h00);
    for (int i = 0; i < 40; i++) begin
      int sel = int'($urandom_range(0, 3));
      int len = (sel == 0) ? 96 : (sel == 1) ? int'($urandom_range(40, 47)) : 48;
      period(len, 8'($urandom), 8'($urandom));
    end
    period(48, 8'h00, 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule